// File: doc/BRIEF.md
# USB Host Control-Endpoint Status and Request Register

This block is the host-side control and status register for a USB control endpoint. It sits between a CPU register port and a transaction engine. The CPU raises requests in it: fetch an IN packet, send a loaded packet, and send that packet with a SETUP token rather than an OUT token. The engine reports outcomes through single-cycle event inputs: packet sent, packet received, STALL handshake and no reply. The register turns these events into sticky status bits and drops the request bits as each one completes.

Each bit has its own write rule. The request for IN packets is plain read/write. The transmit-ready bit and the SETUP-select bit only accept writes of 1. The status bits are cleared only by writing 0 to them. A built-in retry counter counts consecutive unanswered tries. On the third one it flags a timeout, tells the engine to abandon the transfer, and withdraws every pending request. A single interrupt line pulses on the status events and on the completion of a transmit, provided the interrupt is enabled.

Top module: `usb_h_ep0_csr`

## Requirements
- R1: After reset, rd_data, irq, abort, send_in and send_setup_or_out are all zero. Bits 7:6 of rd_data always read 0.
- R2: Bit 5 (IN request) is read/write. A write stores wr_data[5], and send_in equals bit 5.
- R3: An rx_done event sets bit 0 (receive ready) and clears bit 5, even when a CPU write of 1 to bit 5 arrives in the same cycle.
- R4: Bit 1 (transmit ready) and bit 3 (SETUP select) are write-1-to-set, and writing 0 to them has no effect. send_setup_or_out is {bit 1, bit 3}, where 1x means a transmit is requested and x1 means the token is SETUP.
- R5: A tx_done event clears bits 1 and 3, unless the same cycle carries a CPU write of 1 to them.
- R6: Bits 4 (timeout), 2 (stall) and 0 (receive ready) are write-0-to-clear, and writing 1 to them has no effect.
- R7: When a hardware event sets a status bit in the same cycle that a CPU write clears it, the bit ends up set.
- R8: A stall_rcvd event sets bit 2.
- R9: The third consecutive no_response event sets bit 4, clears bits 5, 3 and 1, and raises abort for exactly one cycle. One or two such events change nothing visible.
- R10: The retry count restarts at zero on any tx_done, rx_done or stall_rcvd. It also restarts on a CPU write with wr_data[5] or wr_data[1] set.
- R11: While irq_en is high, irq pulses for one cycle when bit 4, 2 or 0 rises or when bit 1 falls. While irq_en is low, irq stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | CPU write strobe for the register |
| wr_data | input | 8 | CPU write data |
| rd_data | output | 8 | Register read value |
| irq_en | input | 1 | Interrupt enable |
| irq | output | 1 | One-cycle interrupt pulse |
| tx_done | input | 1 | Engine event: packet transmitted |
| rx_done | input | 1 | Engine event: packet received |
| no_response | input | 1 | Engine event: try ended with no reply |
| stall_rcvd | input | 1 | Engine event: STALL handshake received |
| send_in | output | 1 | Request to issue IN tokens |
| send_setup_or_out | output | 2 | {transmit requested, SETUP token selected} |
| abort | output | 1 | One-cycle pulse to abandon the transfer |

## Verification
Every result is registered once. A write or engine event sampled at one clock edge shows up in rd_data, send_in, send_setup_or_out, abort and irq during the cycle that follows, and abort and irq last only that one cycle. The bench drives stimulus just after an edge, waits for the next edge, and samples 1 ns later. It clears the stimulus before checking, so each pulse is inspected in its single valid cycle and again one cycle later to confirm that it has gone. Retry tests count the exact number of unanswered tries, so the timeout is expected on the third try and not earlier.

// File: rtl/usb_ep0_pkg.sv
package usb_ep0_pkg;
  localparam int CSR_W   = 8;
  localparam int BITS_W  = 6;
  localparam int B_RXRDY = 0;
  localparam int B_TXRDY = 1;
  localparam int B_STALL = 2;
  localparam int B_SETUP = 3;
  localparam int B_TOERR = 4;
  localparam int B_REQIN = 5;
  // access classes per bit
  localparam logic [BITS_W-1:0] M_W1S = 6'b001010;
  localparam logic [BITS_W-1:0] M_W0C = 6'b010101;
  localparam logic [BITS_W-1:0] M_RW  = 6'b100000;
  // interrupt sources
  localparam logic [BITS_W-1:0] M_IRQ_RISE = 6'b010101;
  localparam logic [BITS_W-1:0] M_IRQ_FALL = 6'b000010;
endpackage

// File: rtl/ep0_rst_sync.sv
module ep0_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/ep0_retry_ctr.sv
module ep0_retry_ctr #(
  parameter int LIMIT = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic miss,
  output logic give_up
);
  localparam int CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en  = restart | miss;
    give_up = miss && !restart && (cnt_q == LAST);
    if (restart)      cnt_d = '0;
    else if (give_up) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/ep0_irq_gen.sv
module ep0_irq_gen #(
  parameter int W = 6,
  parameter logic [W-1:0] RISE_M = '0,
  parameter logic [W-1:0] FALL_M = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         irq_en,
  input  logic [W-1:0] cur,
  input  logic [W-1:0] nxt,
  output logic         irq
);
  logic irq_q, irq_d;

  always_comb begin
    irq_d = irq_en && (|((nxt & ~cur & RISE_M) | (cur & ~nxt & FALL_M)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq = irq_q;
endmodule

// File: rtl/usb_h_ep0_csr.sv
module usb_h_ep0_csr
  import usb_ep0_pkg::*;
#(
  parameter int RETRY_LIMIT = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CSR_W-1:0] wr_data,
  output logic [CSR_W-1:0] rd_data,
  input  logic             irq_en,
  output logic             irq,
  input  logic             tx_done,
  input  logic             rx_done,
  input  logic             no_response,
  input  logic             stall_rcvd,
  output logic             send_in,
  output logic [1:0]       send_setup_or_out,
  output logic             abort
);
  logic              rst_sync_n;
  logic [BITS_W-1:0] csr_q, csr_d;
  logic [BITS_W-1:0] wr_set, wr_clr, wr_val, hw_set, hw_clr;
  logic              csr_en, restart, give_up, abort_q;

  ep0_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  always_comb begin
    restart = (wr_en && (wr_data[B_REQIN] || wr_data[B_TXRDY]))
              || tx_done || rx_done || stall_rcvd;
  end

  ep0_retry_ctr #(.LIMIT(RETRY_LIMIT)) u_retry (
    .clk(clk), .rst_n(rst_sync_n), .restart(restart),
    .miss(no_response), .give_up(give_up)
  );

  // next-state for the register bank
  always_comb begin
    wr_val = wr_data[BITS_W-1:0];
    wr_set = wr_en ? wr_val  : '0;
    wr_clr = wr_en ? ~wr_val : '0;
    hw_set = '0;
    hw_clr = '0;
    hw_set[B_RXRDY] = rx_done;
    hw_set[B_STALL] = stall_rcvd;
    hw_set[B_TOERR] = give_up;
    hw_clr[B_REQIN] = rx_done | give_up;
    hw_clr[B_TXRDY] = tx_done | give_up;
    hw_clr[B_SETUP] = tx_done | give_up;
    for (int i = 0; i < BITS_W; i++) begin
      if (M_W1S[i])      csr_d[i] = (csr_q[i] & ~hw_clr[i]) | wr_set[i];
      else if (M_W0C[i]) csr_d[i] = (csr_q[i] & ~wr_clr[i]) | hw_set[i];
      else               csr_d[i] = (wr_en ? wr_val[i] : csr_q[i]) & ~hw_clr[i];
    end
    csr_en = wr_en | (|hw_set) | (|hw_clr);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  csr_q <= '0;
    else if (csr_en)  csr_q <= csr_d;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) abort_q <= 1'b0;
    else             abort_q <= give_up;
  end

  ep0_irq_gen #(.W(BITS_W), .RISE_M(M_IRQ_RISE), .FALL_M(M_IRQ_FALL)) u_irq (
    .clk(clk), .rst_n(rst_sync_n), .irq_en(irq_en),
    .cur(csr_q), .nxt(csr_d), .irq(irq)
  );

  assign rd_data           = {{(CSR_W-BITS_W){1'b0}}, csr_q};
  assign send_in           = csr_q[B_REQIN];
  assign send_setup_or_out = {csr_q[B_TXRDY], csr_q[B_SETUP]};
  assign abort             = abort_q;
endmodule

// File: rtl/usb_ep0_csr_chk.sv
module usb_ep0_csr_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [7:0] rd_data,
  input logic       irq_en,
  input logic       irq,
  input logic       tx_done,
  input logic       rx_done,
  input logic       stall_rcvd,
  input logic       abort
);
  a_r1_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[7:6] == 2'b00);

  a_r3_rx_sets_and_drops_req: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> (rd_data[0] && !rd_data[5]));

  a_r5_tx_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_done && !(wr_en && wr_data[1])) |=> !rd_data[1]);

  a_r8_stall_sets: assert property (@(posedge clk) disable iff (!rst_n)
    stall_rcvd |=> rd_data[2]);

  a_r9_abort_flags_timeout: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> rd_data[4]);

  a_r9_abort_single: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !abort);

  a_r11_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(irq_en));
endmodule

bind usb_h_ep0_csr usb_ep0_csr_chk u_chk (
  .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .wr_data(wr_data),
  .rd_data(rd_data), .irq_en(irq_en), .irq(irq), .tx_done(tx_done),
  .rx_done(rx_done), .stall_rcvd(stall_rcvd), .abort(abort)
);

// File: tb/usb_h_ep0_csr_tb.sv
`timescale 1ns/1ps
module usb_h_ep0_csr_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en, irq_en, tx_done, rx_done, no_response, stall_rcvd;
  logic [7:0] wr_data, rd_data;
  logic       irq, send_in, abort;
  logic [1:0] send_setup_or_out;
  int         n_chk = 0;
  int         n_bad = 0;

  always #2.5 clk = ~clk;

  usb_h_ep0_csr u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .irq_en(irq_en), .irq(irq), .tx_done(tx_done),
    .rx_done(rx_done), .no_response(no_response), .stall_rcvd(stall_rcvd),
    .send_in(send_in), .send_setup_or_out(send_setup_or_out), .abort(abort)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
    wr_en = 0; wr_data = 0; tx_done = 0; rx_done = 0;
    no_response = 0; stall_rcvd = 0;
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en = 1; wr_data = d; cyc();
  endtask

  task automatic nr();
    no_response = 1; cyc();
  endtask

  task automatic t_reset();
    chk("R1 rd", rd_data, 8'h00);
    chk("R1 irq/abort/in", {5'b0, irq, abort, send_in}, 8'h00);
    chk("R1 sos", {6'b0, send_setup_or_out}, 8'h00);
  endtask

  task automatic t_req_rw();
    wr(8'h20);
    chk("R2 set", rd_data, 8'h20);
    chk("R2 send_in", {7'b0, send_in}, 8'h01);
    wr(8'h00);
    chk("R2 clear", rd_data, 8'h00);
    wr(8'hE0);
    chk("R1 upper bits zero", rd_data, 8'h20);
    wr(8'h00);
  endtask

  task automatic t_w1s();
    wr(8'h0A);
    chk("R4 set", rd_data, 8'h0A);
    chk("R4 sos", {6'b0, send_setup_or_out}, 8'h03);
    wr(8'h00);
    chk("R4 write0 ignored", rd_data, 8'h0A);
    tx_done = 1; cyc();
    chk("R5 tx clears", rd_data, 8'h00);
    chk("R11 irq tx fall", {7'b0, irq}, 8'h01);
    cyc();
    chk("R11 irq one cycle", {7'b0, irq}, 8'h00);
    wr(8'h02);
    chk("R4 OUT token", {6'b0, send_setup_or_out}, 8'h02);
    tx_done = 1; cyc();
    chk("R5 tx clears OUT", rd_data, 8'h00);
  endtask

  task automatic t_w0c();
    stall_rcvd = 1; cyc();
    chk("R8 stall", rd_data, 8'h04);
    chk("R11 irq stall", {7'b0, irq}, 8'h01);
    rx_done = 1; cyc();
    chk("R3 rx sets", rd_data, 8'h05);
    wr(8'h15);
    chk("R6 write1 ignored", rd_data, 8'h05);
    wr(8'h00);
    chk("R6 write0 clears", rd_data, 8'h00);
  endtask

  task automatic t_collide();
    stall_rcvd = 1; wr_en = 1; wr_data = 8'h00; cyc();
    chk("R7 set wins", rd_data, 8'h04);
    wr(8'h00);
    chk("R7 cleared after", rd_data, 8'h00);
  endtask

  task automatic t_rx_req();
    wr(8'h20);
    rx_done = 1; wr_en = 1; wr_data = 8'h20; cyc();
    chk("R3 req dropped", rd_data, 8'h01);
    chk("R3 send_in low", {7'b0, send_in}, 8'h00);
    wr(8'h00);
  endtask

  task automatic t_timeout();
    wr(8'h0A);
    nr(); nr();
    chk("R9 two misses", rd_data, 8'h0A);
    chk("R9 no abort yet", {7'b0, abort}, 8'h00);
    nr();
    chk("R9 timeout", rd_data, 8'h10);
    chk("R9 abort", {7'b0, abort}, 8'h01);
    chk("R11 irq timeout", {7'b0, irq}, 8'h01);
    chk("R9 sos", {6'b0, send_setup_or_out}, 8'h00);
    cyc();
    chk("R9 abort one cycle", {7'b0, abort}, 8'h00);
    wr(8'h00);
  endtask

  task automatic t_retry_reset();
    wr(8'h02);
    nr(); nr();
    stall_rcvd = 1; cyc();
    nr(); nr();
    chk("R10 response restarts", rd_data, 8'h06);
    nr();
    chk("R10 third after response", rd_data, 8'h14);
    wr(8'h00);
    wr(8'h20);
    nr(); nr();
    wr(8'h20);
    nr(); nr();
    chk("R10 request restarts", rd_data, 8'h20);
    nr();
    chk("R9 IN abandoned", rd_data, 8'h10);
    wr(8'h00);
  endtask

  task automatic t_irq_off();
    irq_en = 0;
    stall_rcvd = 1; cyc();
    chk("R11 gated", {7'b0, irq}, 8'h00);
    chk("R8 stall while gated", rd_data, 8'h04);
    irq_en = 1;
    wr(8'h00);
    chk("R11 no irq on clear", {7'b0, irq}, 8'h00);
    rx_done = 1; cyc();
    chk("R11 irq rx", {7'b0, irq}, 8'h01);
    wr(8'h00);
  endtask

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 0; irq_en = 1;
    wr_en = 0; wr_data = 0; tx_done = 0; rx_done = 0;
    no_response = 0; stall_rcvd = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (3) cyc();
    t_reset();
    t_req_rw();
    t_w1s();
    t_w0c();
    t_collide();
    t_rx_req();
    t_timeout();
    t_retry_reset();
    t_irq_off();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule